// File: doc/BRIEF.md
# Display Refresh Phase Sequencer

This block drives the power and waveform phases of an electrophoretic panel refresh from the controller side. Software writes an 8-bit phase-enable mask into a holding register. Writing the mask starts nothing. A separate activation strobe takes a copy of the mask and walks through the enabled phases. The walk always runs from the highest mask bit to the lowest. While a phase runs, the block raises that phase's output strobe for a fixed number of cycles. Each phase's duration comes from a parameter that depends on its class: power switching, table or sensor loading, or panel drive.

Mask bits 7 and 0 start and stop the oscillator. Bits 6 and 1 bring the analog rails up and shut them down. Bit 5 loads the temperature and bit 4 loads the waveform table. Bit 2 drives the panel. Bit 3 is not a phase: it selects whether the drive phase uses its second mode.

A busy flag stays high for the whole run. The block also keeps two status flags, one for the oscillator and one for the rails. These flags carry over from one run to the next, so a mask that leaves power on lets a later refresh mask omit the power-up phases.

Top module: `upd_phase_seq`

## Requirements
- R1: After reset, `busy`, `phase_act`, `drive_mode2`, `clk_on` and `rails_on` are all 0.
- R2: Writing the mask (`mask_we`) without `trigger` starts no run: `busy` and `phase_act` stay 0.
- R3: Enabled phases run in descending bit order (7, 6, 5, 4, 2, 1, 0), and disabled phases take no cycles. Bits 7, 6, 1 and 0 each last LEN_POWER cycles, bits 5 and 4 each last LEN_LOAD cycles, and bit 2 lasts LEN_DRIVE cycles. A trigger sampled at clock edge N makes the first enabled phase visible from edge N onward.
- R4: `busy` is 1 from the edge that accepts the trigger until the edge that ends the last enabled phase. During that time exactly one bit of `phase_act` is 1, and that bit's position equals the mask bit of the running phase. When `busy` is 0, `phase_act` is 0.
- R5: A trigger whose mask has none of bits 7, 6, 5, 4, 2, 1, 0 set (for example 0x00 or 0x08) leaves `busy` at 0.
- R6: A trigger that arrives while `busy` is 1 is ignored. A run uses the mask register value held before the trigger edge, so a mask write in the same cycle as the trigger, or during a run, affects only later runs.
- R7: `clk_on` becomes 1 at the end of a bit-7 phase and 0 at the end of a bit-0 phase. `rails_on` does the same for bit 6 and bit 1. Both flags hold their value across runs and never change while `busy` is 0.
- R8: `drive_mode2` is 1 exactly during the bit-2 phase of a run whose mask had bit 3 set. Otherwise it is 0.
- R9: `phase_act[3]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_we | input | 1 | Write strobe for the phase-enable mask |
| mask_wdata | input | 8 | Mask value to write |
| trigger | input | 1 | Activation strobe that starts a run |
| busy | output | 1 | High while a run is in progress |
| phase_act | output | 8 | One-hot strobe of the running phase, indexed by mask bit |
| drive_mode2 | output | 1 | Drive phase is running in mode 2 |
| clk_on | output | 1 | Oscillator is currently on |
| rails_on | output | 1 | Analog rails are currently on |

## Verification
A corrupted current-phase register shows up on `phase_act` within one cycle: the bench either sees the wrong bit or sees bits appear out of descending order. A miscounting phase timer changes how long a strobe stays high, and that is visible at the next phase boundary. A wrong status update only shows after the run ends, through `clk_on` or `rails_on`. The bench checks those flags after every run, so a fault appears within one run. Sweeping all 256 masks in sequence crosses every status transition and every mode-bit combination, and stray triggers are injected during runs and at their final cycle.

// File: rtl/upd_seq_pkg.sv
package upd_seq_pkg;
  localparam int unsigned NPH        = 8;
  localparam int unsigned B_OSC_ON   = 7;
  localparam int unsigned B_RAIL_ON  = 6;
  localparam int unsigned B_TEMP     = 5;
  localparam int unsigned B_LUT      = 4;
  localparam int unsigned B_MODE     = 3;
  localparam int unsigned B_DRIVE    = 2;
  localparam int unsigned B_RAIL_OFF = 1;
  localparam int unsigned B_OSC_OFF  = 0;

  typedef enum logic [1:0] {CLS_POWER, CLS_LOAD, CLS_DRIVE} len_cls_e;

  function automatic len_cls_e cls_of(input logic [2:0] b);
    if (b == 3'(B_DRIVE))                         return CLS_DRIVE;
    else if (b == 3'(B_TEMP) || b == 3'(B_LUT))   return CLS_LOAD;
    else                                          return CLS_POWER;
  endfunction
endpackage

// File: rtl/upd_seq_pick.sv
module upd_seq_pick #(
  parameter int unsigned W  = 8,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  input  logic [IW:0]   below,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (req[i] && (i < int'(below))) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/upd_seq_timer.sv
module upd_seq_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign last   = run && (cnt_q == limit - CW'(1));
  assign cnt_en = restart || run;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)  cnt_d = '0;
    else if (run) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));
endmodule

// File: rtl/upd_phase_seq.sv
module upd_phase_seq
  import upd_seq_pkg::*;
#(
  parameter int unsigned LEN_POWER = 2,
  parameter int unsigned LEN_LOAD  = 3,
  parameter int unsigned LEN_DRIVE = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mask_we,
  input  logic [7:0] mask_wdata,
  input  logic       trigger,
  output logic       busy,
  output logic [7:0] phase_act,
  output logic       drive_mode2,
  output logic       clk_on,
  output logic       rails_on
);
  localparam int unsigned LMAX = (LEN_POWER > LEN_LOAD) ?
                                 ((LEN_POWER > LEN_DRIVE) ? LEN_POWER : LEN_DRIVE) :
                                 ((LEN_LOAD > LEN_DRIVE) ? LEN_LOAD : LEN_DRIVE);
  localparam int unsigned CW = $clog2(LMAX + 1);
  localparam int unsigned IW = $clog2(NPH);
  localparam logic [NPH-1:0] MODE_BIT = NPH'(1) << B_MODE;

  logic [NPH-1:0] mask_q;
  logic [NPH-1:0] run_q, run_d;
  logic           mode_q, mode_d;
  logic           busy_q, busy_d;
  logic [IW-1:0]  cur_q, cur_d;
  logic           clk_on_q, clk_on_d;
  logic           rail_q, rail_d;

  logic           start;
  logic           tmr_last;
  logic           nxt_found;
  logic [IW-1:0]  nxt_idx;
  logic [IW:0]    pick_below;
  logic [NPH-1:0] pick_req;
  logic [CW-1:0]  len_sel;
  logic [NPH-1:0] phase_mask;

  assign phase_mask = mask_q & ~MODE_BIT;
  assign start      = trigger && !busy_q;
  assign pick_req   = busy_q ? run_q : phase_mask;
  assign pick_below = busy_q ? {1'b0, cur_q} : (IW+1)'(NPH);

  upd_seq_pick #(.W(NPH)) u_pick (
    .req   (pick_req),
    .below (pick_below),
    .found (nxt_found),
    .idx   (nxt_idx)
  );

  always_comb begin
    unique case (cls_of(cur_q))
      CLS_DRIVE: len_sel = CW'(LEN_DRIVE);
      CLS_LOAD:  len_sel = CW'(LEN_LOAD);
      default:   len_sel = CW'(LEN_POWER);
    endcase
  end

  upd_seq_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy_q),
    .restart (start || tmr_last),
    .limit   (len_sel),
    .last    (tmr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  always_comb begin
    busy_d   = busy_q;
    cur_d    = cur_q;
    run_d    = run_q;
    mode_d   = mode_q;
    clk_on_d = clk_on_q;
    rail_d   = rail_q;
    if (start) begin
      if (nxt_found) begin
        busy_d = 1'b1;
        cur_d  = nxt_idx;
        run_d  = phase_mask;
        mode_d = mask_q[B_MODE];
      end
    end else if (tmr_last) begin
      if (cur_q == IW'(B_OSC_ON))   clk_on_d = 1'b1;
      if (cur_q == IW'(B_OSC_OFF))  clk_on_d = 1'b0;
      if (cur_q == IW'(B_RAIL_ON))  rail_d   = 1'b1;
      if (cur_q == IW'(B_RAIL_OFF)) rail_d   = 1'b0;
      if (nxt_found) cur_d  = nxt_idx;
      else           busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cur_q    <= '0;
      run_q    <= '0;
      mode_q   <= 1'b0;
      clk_on_q <= 1'b0;
      rail_q   <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      cur_q    <= cur_d;
      run_q    <= run_d;
      mode_q   <= mode_d;
      clk_on_q <= clk_on_d;
      rail_q   <= rail_d;
    end
  end

  assign busy        = busy_q;
  assign phase_act   = busy_q ? (NPH'(1) << cur_q) : '0;
  assign drive_mode2 = busy_q && (cur_q == IW'(B_DRIVE)) && mode_q;
  assign clk_on      = clk_on_q;
  assign rails_on    = rail_q;

  assert_one_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(phase_act) == 1));
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (phase_act == '0));
  assert_descending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tmr_last && nxt_found) |=> (cur_q < $past(cur_q)));
  assert_status_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> ($stable(clk_on_q) && $stable(rail_q)));
  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tmr_last) |=> (busy_q && $stable(cur_q)));
  assert_mode_in_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drive_mode2 |-> phase_act[B_DRIVE]);
  assert_no_mode_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_act[B_MODE]);
endmodule

// File: tb/upd_phase_seq_tb.sv
module upd_phase_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LP = 2;
  localparam int LL = 3;
  localparam int LD = 5;

  logic       clk, rst_n, mask_we, trigger;
  logic [7:0] mask_wdata;
  logic       busy, drive_mode2, clk_on, rails_on;
  logic [7:0] phase_act;

  int  total, bad;
  bit  done;
  logic m_clk, m_rail;

  upd_phase_seq #(.LEN_POWER(LP), .LEN_LOAD(LL), .LEN_DRIVE(LD)) u_dut (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .trigger(trigger), .busy(busy), .phase_act(phase_act),
    .drive_mode2(drive_mode2), .clk_on(clk_on), .rails_on(rails_on)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int tb_len(input int b);
    if (b == 2) return LD;
    if (b == 5 || b == 4) return LL;
    return LP;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] outs();
    return {busy, drive_mode2, phase_act};
  endfunction

  task automatic run(input logic [7:0] m, input int inj);
    int k;
    bit ok;
    logic [9:0] fa, fe, e;
    @(negedge clk); mask_we = 1'b1; mask_wdata = m;
    @(negedge clk); mask_we = 1'b0; trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    k = 0; ok = 1'b1; fa = '0; fe = '0;
    for (int b = 7; b >= 0; b--) begin
      if (b != 3 && m[b]) begin
        for (int c = 0; c < tb_len(b); c++) begin
          e = {1'b1, (b == 2) && m[3], 8'(1 << b)};
          if (outs() !== e && ok) begin ok = 1'b0; fa = outs(); fe = e; end
          if (k == inj) begin trigger = 1'b1; mask_we = 1'b1; mask_wdata = ~m; end
          else begin trigger = 1'b0; mask_we = 1'b0; end
          k++;
          @(negedge clk);
        end
        if (b == 7) m_clk = 1'b1;
        if (b == 0) m_clk = 1'b0;
        if (b == 6) m_rail = 1'b1;
        if (b == 1) m_rail = 1'b0;
      end
    end
    trigger = 1'b0; mask_we = 1'b0;
    chk(ok, $sformatf("R3 R4 R8 R9 schedule mask=%h", m), 32'(fa), 32'(fe));
    chk(outs() === 10'd0, $sformatf("R4 R5 R6 end idle mask=%h", m), 32'(outs()), 0);
    chk({clk_on, rails_on} === {m_clk, m_rail}, $sformatf("R7 status mask=%h", m),
        32'({clk_on, rails_on}), 32'({m_clk, m_rail}));
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    m_clk = 1'b0; m_rail = 1'b0;
    rst_n = 1'b0; mask_we = 1'b0; trigger = 1'b0; mask_wdata = '0;
    repeat (3) @(negedge clk);
    chk({outs(), clk_on, rails_on} === 12'd0, "R1 reset", 32'({outs(), clk_on, rails_on}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = 8'hF4;
    @(negedge clk); mask_we = 1'b0;
    repeat (4) @(negedge clk);
    chk(outs() === 10'd0, "R2 write alone", 32'(outs()), 0);
    run(8'hF4, -1);
    run(8'h34, -1);
    run(8'h0C, 2);
    run(8'h83, LP + LP - 1);
    run(8'h08, -1);
    @(negedge clk); mask_we = 1'b1; mask_wdata = 8'h40;
    @(negedge clk); mask_wdata = 8'h02; trigger = 1'b1;
    @(negedge clk); mask_we = 1'b0; trigger = 1'b0;
    chk(phase_act === 8'h40, "R6 same-cycle write", 32'(phase_act), 32'h40);
    repeat (LP) @(negedge clk);
    chk(outs() === 10'd0 && rails_on === 1'b1, "R6 R7 after rail-on", 32'({outs(), rails_on}), 1);
    trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    chk(phase_act === 8'h02, "R6 later mask used", 32'(phase_act), 32'h02);
    repeat (LP) @(negedge clk);
    chk(rails_on === 1'b0, "R7 rail-off", 32'(rails_on), 0);
    m_rail = 1'b0;
    for (int m = 0; m < 256; m++) run(8'(m), (m % 5 == 0) ? (m % 7) : -1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule